// File: doc/BRIEF.md
# Multi-Queue Linked-List Buffer Manager

This block keeps track of a fixed pool of equal-sized data buffers that several first-in first-out queues share. Every buffer is a node. Unused nodes sit on a free list. Each queue is a singly linked chain with its own head and tail pointers. The pointer from each node to the next one is stored in a link memory of its own. That memory is separate from wherever the payload is kept, and the payload itself is not handled here.

A client issues one request per cycle. A request carries an operation (append or remove) and a queue number. An append takes the node at the head of the free list and links it onto the tail of the chosen queue. A remove unlinks the head node of the chosen queue and returns that node to the tail of the free list. In both cases the block answers with the node index and its byte address in buffer memory. The byte address is the node index times the power-of-two buffer size.

At reset the link memory is filled so that every node is chained into the free list in ascending order, and all queues start empty. A request that cannot be served is refused and flagged in the response. This covers an append when no node is free and a remove from an empty queue.

Top module: `qlist_mgr`

## Requirements
- R1: During reset and link-memory initialisation `op_ready` is 0. Once initialisation has finished, `op_ready` is 1, every bit of `q_empty` is 1 and `free_empty` is 0.
- R2: An accepted append (`op_kind`=0) returns the node at the head of the free list. From the initial state the nodes come out in ascending order 0, 1, 2, ….
- R3: Within each queue, accepted removes (`op_kind`=1) return nodes in exactly the order in which they were appended to that queue.
- R4: A removed node is placed at the tail of the free list. It is handed out again only after every node that was already free.
- R5: An append accepted while `free_empty`=1 is answered with `resp_err`=1 and changes no queue or free-list state.
- R6: A remove accepted while the addressed queue's `q_empty` bit is 1 is answered with `resp_err`=1 and changes no state.
- R7: Each request accepted on a clock edge (`op_valid`=1 and `op_ready`=1) gives `resp_valid`=1 for exactly the following cycle, together with that request's `resp_err`, `resp_node` and `resp_addr`.
- R8: On a successful response, `resp_addr` equals `resp_node` multiplied by `BUF_BYTES`.
- R9: Suppose an accepted, successful request takes its node from a list that held more than one node. Then `op_ready` is 0 for exactly one cycle afterwards. If the list held a single node, `op_ready` stays 1.
- R10: `q_empty[i]` is 1 exactly when queue i holds no node, and `free_empty` is 1 exactly when all nodes are in queues. Both are updated on the edge that accepts the request.
- R11: `op_valid` asserted while `op_ready` is 0 has no effect: no response and no state change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Request present |
| op_kind | input | 1 | 0 = append to queue, 1 = remove from queue |
| op_qid | input | QID_W | Queue number |
| op_ready | output | 1 | Request is taken on this edge when high |
| resp_valid | output | 1 | Response for the request accepted one edge earlier |
| resp_err | output | 1 | Request refused (no free node or empty queue) |
| resp_node | output | NODE_W | Node index allocated or released |
| resp_addr | output | ADDR_W | Byte address of that node's buffer |
| q_empty | output | N_QUEUES | Per-queue empty flags |
| free_empty | output | 1 | Free list is exhausted |

## Verification
Every response, and every change to the empty flags, shows up one clock after the edge that accepts the request. The only exception is the busy cycle: `op_ready` drops for the cycle right after a successful pop from a list holding several nodes. The bench drives inputs and samples outputs on the falling edge. At each falling edge it first compares the outputs against its behavioural queue model, then drives new stimulus and advances the model by one edge, so every expectation lands exactly one register stage after its cause. Requests issued while the model predicts `op_ready` low are left out of the model on purpose. Any response or flag change that follows them is therefore caught.

// File: rtl/qlist_pkg.sv
package qlist_pkg;

   typedef enum logic {
      OP_APPEND = 1'b0,
      OP_REMOVE = 1'b1
   } op_kind_e;

   typedef enum logic [1:0] {
      ST_INIT = 2'd0,
      ST_IDLE = 2'd1,
      ST_WAIT = 2'd2
   } ctrl_st_e;

endpackage

// File: rtl/qlist_link_ram.sv
// Next-pointer store: one word per node, registered read (1 cycle latency).
module qlist_link_ram #(
   parameter int DEPTH      = 16,
   parameter int AW         = 4,
   parameter bit INIT_SWEEP = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] rd_addr,
   output logic [AW-1:0] rd_data,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [AW-1:0] wr_data,
   output logic          init_done
);

   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   logic [AW-1:0] mem [DEPTH];

   function automatic logic [AW-1:0] succ(input logic [AW-1:0] idx);
      return (idx == LAST) ? '0 : idx + 1'b1;
   endfunction

   generate
      if (INIT_SWEEP) begin : g_sweep
         // Walk every entry once after reset, chaining node i to node i+1.
         logic [AW-1:0] sweep_idx;
         logic          sweeping;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sweep_idx <= '0;
               sweeping  <= 1'b1;
            end else if (sweeping) begin
               sweep_idx <= succ(sweep_idx);
               if (sweep_idx == LAST) sweeping <= 1'b0;
            end
         end

         always_ff @(posedge clk) begin
            if (sweeping)   mem[sweep_idx] <= succ(sweep_idx);
            else if (wr_en) mem[wr_addr]   <= wr_data;
         end

         assign init_done = !sweeping;
      end else begin : g_flop_reset
         // Small pools: load the free chain straight from reset.
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) mem[i] <= succ(AW'(i));
            end else if (wr_en) begin
               mem[wr_addr] <= wr_data;
            end
         end

         assign init_done = 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      rd_data <= mem[rd_addr];
   end

endmodule

// File: rtl/qlist_slot.sv
// Head/tail/count registers of one list (a queue or the free list).
module qlist_slot #(
   parameter int N_NODES = 16,
   parameter int NODE_W  = 4,
   parameter int CNT_W   = 5,
   parameter bit IS_FREE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [NODE_W-1:0] push_node,
   input  logic              pop,
   input  logic              load,
   input  logic [NODE_W-1:0] load_node,
   output logic [NODE_W-1:0] head,
   output logic [NODE_W-1:0] tail,
   output logic              empty,
   output logic              multi
);

   localparam logic [CNT_W-1:0]  CNT_RST  = IS_FREE ? CNT_W'(N_NODES) : '0;
   localparam logic [NODE_W-1:0] TAIL_RST = IS_FREE ? NODE_W'(N_NODES - 1) : '0;

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head <= '0;
         tail <= TAIL_RST;
         cnt  <= CNT_RST;
      end else begin
         if (push) begin
            tail <= push_node;
            if (cnt == '0) head <= push_node;
         end
         if (load) head <= load_node;
         if (push && !pop)      cnt <= cnt + 1'b1;
         else if (pop && !push) cnt <= cnt - 1'b1;
      end
   end

   assign empty = (cnt == '0);
   assign multi = (cnt > CNT_W'(1));

endmodule

// File: rtl/qlist_ctrl.sv
// Accept/wait sequencing: one request per cycle, one stall cycle while
// the next pointer of a popped node is being fetched.
module qlist_ctrl
   import qlist_pkg::*;
#(
   parameter int LIST_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              init_done,
   input  logic              op_valid,
   input  logic [LIST_W-1:0] src_idx,
   input  logic              src_empty,
   input  logic              src_multi,
   output logic              op_ready,
   output logic              take_ok,
   output logic              take_err,
   output logic              head_load,
   output logic [LIST_W-1:0] pend_idx
);

   ctrl_st_e st;
   logic     take;

   assign op_ready  = (st == ST_IDLE);
   assign take      = op_valid && op_ready;
   assign take_ok   = take && !src_empty;
   assign take_err  = take && src_empty;
   assign head_load = (st == ST_WAIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_INIT;
         pend_idx <= '0;
      end else begin
         unique case (st)
            ST_INIT: if (init_done) st <= ST_IDLE;
            ST_IDLE: if (take_ok && src_multi) begin
               st       <= ST_WAIT;
               pend_idx <= src_idx;
            end
            ST_WAIT: st <= ST_IDLE;
            default: st <= ST_INIT;
         endcase
      end
   end

endmodule

// File: rtl/qlist_mgr.sv
module qlist_mgr
   import qlist_pkg::*;
#(
   parameter  int N_NODES    = 16,
   parameter  int N_QUEUES   = 4,
   parameter  int BUF_BYTES  = 64,
   parameter  bit INIT_SWEEP = 1'b1,
   localparam int NODE_W     = $clog2(N_NODES),
   localparam int QID_W      = $clog2(N_QUEUES),
   localparam int SHIFT      = $clog2(BUF_BYTES),
   localparam int ADDR_W     = NODE_W + SHIFT
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                op_valid,
   input  logic                op_kind,
   input  logic [QID_W-1:0]    op_qid,
   output logic                op_ready,
   output logic                resp_valid,
   output logic                resp_err,
   output logic [NODE_W-1:0]   resp_node,
   output logic [ADDR_W-1:0]   resp_addr,
   output logic [N_QUEUES-1:0] q_empty,
   output logic                free_empty
);

   localparam int N_LISTS  = N_QUEUES + 1;
   localparam int LIST_W   = $clog2(N_LISTS);
   localparam int CNT_W    = $clog2(N_NODES + 1);
   localparam int FREE_IDX = N_QUEUES;

   // Elaboration-time parameter checks.
   if (N_NODES < 2) begin : g_bad_nodes
      $error("qlist_mgr: N_NODES must be at least 2");
   end
   if (N_QUEUES < 2 || (1 << QID_W) != N_QUEUES) begin : g_bad_queues
      $error("qlist_mgr: N_QUEUES must be a power of two, at least 2");
   end
   if (BUF_BYTES < 1 || (1 << SHIFT) != BUF_BYTES) begin : g_bad_buf
      $error("qlist_mgr: BUF_BYTES must be a power of two");
   end

   logic [NODE_W-1:0] head_a  [N_LISTS];
   logic [NODE_W-1:0] tail_a  [N_LISTS];
   logic [N_LISTS-1:0] empty_v, multi_v;

   logic [LIST_W-1:0] src_idx, dst_idx, pend_idx;
   logic              take_ok, take_err, head_load, init_done;
   logic [NODE_W-1:0] node, link_rd;

   // Append: free list -> queue. Remove: queue -> free list.
   assign src_idx = (op_kind == OP_REMOVE) ? LIST_W'(op_qid) : LIST_W'(FREE_IDX);
   assign dst_idx = (op_kind == OP_REMOVE) ? LIST_W'(FREE_IDX) : LIST_W'(op_qid);
   assign node    = head_a[src_idx];

   qlist_ctrl #(.LIST_W(LIST_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .init_done (init_done),
      .op_valid  (op_valid),
      .src_idx   (src_idx),
      .src_empty (empty_v[src_idx]),
      .src_multi (multi_v[src_idx]),
      .op_ready  (op_ready),
      .take_ok   (take_ok),
      .take_err  (take_err),
      .head_load (head_load),
      .pend_idx  (pend_idx)
   );

   // Read the successor of the popped node; link it behind the old tail.
   qlist_link_ram #(
      .DEPTH      (N_NODES),
      .AW         (NODE_W),
      .INIT_SWEEP (INIT_SWEEP)
   ) u_link (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_addr   (node),
      .rd_data   (link_rd),
      .wr_en     (take_ok && !empty_v[dst_idx]),
      .wr_addr   (tail_a[dst_idx]),
      .wr_data   (node),
      .init_done (init_done)
   );

   for (genvar g = 0; g < N_LISTS; g++) begin : g_list
      qlist_slot #(
         .N_NODES (N_NODES),
         .NODE_W  (NODE_W),
         .CNT_W   (CNT_W),
         .IS_FREE (g == FREE_IDX)
      ) u_slot (
         .clk       (clk),
         .rst_n     (rst_n),
         .push      (take_ok && (dst_idx == LIST_W'(g))),
         .push_node (node),
         .pop       (take_ok && (src_idx == LIST_W'(g))),
         .load      (head_load && (pend_idx == LIST_W'(g))),
         .load_node (link_rd),
         .head      (head_a[g]),
         .tail      (tail_a[g]),
         .empty     (empty_v[g]),
         .multi     (multi_v[g])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         resp_valid <= 1'b0;
         resp_err   <= 1'b0;
         resp_node  <= '0;
      end else begin
         resp_valid <= take_ok || take_err;
         resp_err   <= take_err;
         if (take_ok) resp_node <= node;
      end
   end

   generate
      if (SHIFT == 0) begin : g_addr_unit
         assign resp_addr = resp_node;
      end else begin : g_addr_shift
         assign resp_addr = {resp_node, {SHIFT{1'b0}}};
      end
   endgenerate

   assign q_empty    = empty_v[N_QUEUES-1:0];
   assign free_empty = empty_v[FREE_IDX];

endmodule

// File: rtl/qlist_mgr_chk.sv
module qlist_mgr_chk #(
   parameter int N_QUEUES = 4,
   parameter int QID_W    = 2
) (
   input logic                clk,
   input logic                rst_n,
   input logic                op_valid,
   input logic                op_kind,
   input logic [QID_W-1:0]    op_qid,
   input logic                op_ready,
   input logic                resp_valid,
   input logic                resp_err,
   input logic [N_QUEUES-1:0] q_empty,
   input logic                free_empty
);

   AST_RESP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_ready) |=> resp_valid); // R7

   AST_NO_SPURIOUS_RESP: assert property (@(posedge clk) disable iff (!rst_n)
      !(op_valid && op_ready) |=> !resp_valid); // R11

   AST_APPEND_EXHAUSTED: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_ready && !op_kind && free_empty) |=> resp_err); // R5

   AST_REMOVE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_ready && op_kind && q_empty[op_qid]) |=> resp_err); // R6

   AST_ERR_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid && resp_err) |-> ($stable(q_empty) && $stable(free_empty))); // R5

   AST_SINGLE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(op_ready) |=> op_ready); // R9

endmodule

bind qlist_mgr qlist_mgr_chk #(
   .N_QUEUES (N_QUEUES),
   .QID_W    (QID_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .op_valid   (op_valid),
   .op_kind    (op_kind),
   .op_qid     (op_qid),
   .op_ready   (op_ready),
   .resp_valid (resp_valid),
   .resp_err   (resp_err),
   .q_empty    (q_empty),
   .free_empty (free_empty)
);

// File: tb/qlist_mgr_test.sv
`timescale 1ns/1ps
module qlist_mgr_test;

   localparam int NN     = 16;
   localparam int NQ     = 4;
   localparam int BB     = 64;
   localparam int NW     = $clog2(NN);
   localparam int QW     = $clog2(NQ);
   localparam int AW     = NW + $clog2(BB);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          op_valid = 1'b0;
   logic          op_kind = 1'b0;
   logic [QW-1:0] op_qid = '0;
   logic          op_ready, resp_valid, resp_err, free_empty;
   logic [NW-1:0] resp_node;
   logic [AW-1:0] resp_addr;
   logic [NQ-1:0] q_empty;

   always #2.5 clk = ~clk;

   qlist_mgr #(.N_NODES(NN), .N_QUEUES(NQ), .BUF_BYTES(BB)) uut (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
      .op_qid(op_qid), .op_ready(op_ready), .resp_valid(resp_valid),
      .resp_err(resp_err), .resp_node(resp_node), .resp_addr(resp_addr),
      .q_empty(q_empty), .free_empty(free_empty)
   );

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   // Behavioural reference: plain queues of node numbers.
   int fl [$];
   int mq [NQ][$];
   bit exp_ready;
   bit exp_rv;
   bit exp_err;
   int exp_node;
   string node_tag;
   string err_tag;
   bit any_removed = 1'b0;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
      end
   endtask

   task automatic compare();
      logic [NQ-1:0] e;
      for (int i = 0; i < NQ; i++) e[i] = (mq[i].size() == 0);
      check(op_ready == exp_ready, "R9 op_ready", int'(op_ready), int'(exp_ready));
      check(resp_valid == exp_rv, exp_rv ? "R7 resp_valid" : "R11 resp_valid",
            int'(resp_valid), int'(exp_rv));
      if (exp_rv) begin
         check(resp_err == exp_err, err_tag, int'(resp_err), int'(exp_err));
         if (!exp_err) begin
            check(int'(resp_node) == exp_node, node_tag, int'(resp_node), exp_node);
            check(int'(resp_addr) == exp_node * BB, "R8 resp_addr",
                  int'(resp_addr), exp_node * BB);
         end
      end
      check(q_empty == e, "R10 q_empty", int'(q_empty), int'(e));
      check(free_empty == (fl.size() == 0), "R10 free_empty",
            int'(free_empty), int'(fl.size() == 0));
   endtask

   task automatic model(input bit v, input bit k, input int q);
      if (v && exp_ready) begin
         int sz;
         exp_rv = 1'b1;
         if (!k) begin
            err_tag = "R5 resp_err";
            sz = fl.size();
            exp_err = (sz == 0);
            if (!exp_err) begin
               exp_node = fl.pop_front();
               mq[q].push_back(exp_node);
               node_tag = any_removed ? "R4 resp_node" : "R2 resp_node";
            end
         end else begin
            err_tag = "R6 resp_err";
            sz = mq[q].size();
            exp_err = (sz == 0);
            if (!exp_err) begin
               exp_node = mq[q].pop_front();
               fl.push_back(exp_node);
               node_tag = "R3 resp_node";
               any_removed = 1'b1;
            end
         end
         exp_ready = !(!exp_err && sz > 1);
      end else begin
         exp_rv = 1'b0;
         exp_ready = 1'b1;
      end
   endtask

   task automatic step(input bit v, input bit k, input int q);
      compare();
      op_valid = v;
      op_kind  = k;
      op_qid   = QW'(q);
      model(v, k, q);
      @(negedge clk);
   endtask

   task automatic do_op(input bit k, input int q);
      if (!exp_ready) step(1'b1, ~k, (q + 1) % NQ); // R11: ignored while busy
      step(1'b1, k, q);
   endtask

   initial begin
      int wait_cyc;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(op_ready == 1'b0, "R1 ready in reset", int'(op_ready), 0);
      check(resp_valid == 1'b0, "R1 resp in reset", int'(resp_valid), 0);
      rst_n = 1'b1;
      wait_cyc = 0;
      while (!op_ready && wait_cyc < NN + 8) begin
         @(negedge clk);
         wait_cyc++;
      end
      check(op_ready == 1'b1, "R1 ready after init", int'(op_ready), 1);
      check(q_empty == '1, "R1 queues empty", int'(q_empty), (1 << NQ) - 1);
      check(free_empty == 1'b0, "R1 free list full", int'(free_empty), 0);

      for (int i = 0; i < NN; i++) fl.push_back(i);
      exp_ready = 1'b1;
      exp_rv    = 1'b0;
      exp_err   = 1'b0;
      exp_node  = 0;
      node_tag  = "R2 resp_node";
      err_tag   = "R5 resp_err";

      // Exhaust the pool over all queues, then one append too many (R2, R5).
      for (int i = 0; i <= NN; i++) do_op(1'b0, i % NQ);
      // Drain every queue plus one extra remove each (R3, R6).
      for (int q = 0; q < NQ; q++)
         for (int i = 0; i <= NN / NQ; i++) do_op(1'b1, q);
      // Reuse order of recycled nodes (R4).
      for (int i = 0; i < 6; i++) do_op(1'b0, 2);
      for (int i = 0; i < 6; i++) do_op(1'b1, 2);
      // Single-node queue: no stall on its removal (R9).
      do_op(1'b0, 1);
      do_op(1'b1, 1);
      step(1'b0, 1'b0, 0);

      // Random traffic in phases with shifting bias.
      for (int ph = 0; ph < 4; ph++) begin
         for (int i = 0; i < 1500; i++) begin
            int r = $urandom_range(0, 99);
            bit v = (r < 80);
            int lim = (ph == 0) ? 70 : (ph == 1) ? 30 : (ph == 2) ? 50 : 90;
            bit k = ($urandom_range(0, 99) >= lim);
            int q = (ph == 3) ? 0 : $urandom_range(0, NQ - 1);
            step(v, k, q);
         end
      end
      step(1'b0, 1'b0, 0);
      compare();

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_err++;
         n_chk++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

endmodule